// File: doc/BRIEF.md
# Configurable-Rate Decimating FIR Engine

This block lowpass-filters and decimates one stream of complex I/Q samples with a set of real coefficients. A 3-bit select chooses the decimation factor from 1, 2, 4, 8 and 16. The filter length grows with the factor at eight taps per unit of decimation, so 16, 32, 64 or 128 taps are used. Factor 1 is a bypass with no filtering at all. Because length over factor is fixed, one set of four multipliers covers every rate at a clock four times the sample rate. Two multipliers serve the I rail and two serve the Q rail, and each pair handles two taps per clock.

The sample history sits in a circular store indexed by a write pointer. Coefficients sit in a separate store that software loads through a simple write port. Both stores are read in the same cycle, walking back from the newest sample one tap at a time. A change of the rate select flushes the history and the accumulators. Output then stays silent until enough fresh samples have arrived to fill the new filter length.

Top module: `decim_fir_engine`

## Requirements
- R1: `rate_sel` value 0 selects bypass, 1 selects factor 2 with 16 taps, 2 selects factor 4 with 32 taps, 3 selects factor 8 with 64 taps, and any value from 4 to 7 selects factor 16 with 128 taps.
- R2: Input samples arrive no more often than one every 4 clock cycles. At that rate, every filter pass finishes on the 4 shared multipliers before the next pass must start.
- R3: In filter mode, each output rail equals the sum over k of h[k]·x[n−k] for k from 0 to N−1, arithmetically shifted right by 15. Here x[n] is the newest sample of that rail, and I and Q use the same coefficients.
- R4: In bypass mode, every accepted input appears on the output one clock later, sign-extended to 18 bits and otherwise unchanged.
- R5: After a restart, the first filter output uses the N-th accepted sample as its newest sample. After that, one output follows every D further samples, where D is the decimation factor.
- R6: `out_valid` stays low in filter mode until N samples have been accepted since the last restart.
- R7: A change of the selected rate (the value after the R1 mapping) ignores the input in that cycle and holds `out_valid` low on the next clock. It also aborts any pass in progress and discards all earlier samples.
- R8: Filter outputs saturate to the signed 18-bit range [−131072, 131071].
- R9: A write with `cw_en` high stores `cw_data` at coefficient address `cw_addr`. Address k multiplies the k-th newest sample, where k = 0 is the newest.
- R10: During and right after reset, `out_valid`, `out_i` and `out_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, four times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Decimation rate select |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | 7 | Coefficient write address (tap index) |
| cw_data | input | 16 | Coefficient value, signed, scaled by 2^15 |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 18 | Output in-phase sample, signed |
| out_q | output | 18 | Output quadrature sample, signed |

## Verification
A bad write pointer, tap address walk or coefficient address shows up as a wrong value on the first filter output after a fill. That output appears within one pass of the N-th sample, which is at most 70 clocks. A bad fill or phase count moves outputs to the wrong samples. The bench sees this either as an unexpected strobe or as a wrong total count once the stream has drained. A missing flush is exposed when a rate change follows a partly filled stream: stale samples make the first new output arrive early or carry the wrong value.

// File: rtl/decim_pkg.sv
package decim_pkg;
  // Tag that travels alongside one pair of taps through the MAC pipeline
  typedef struct packed {
    logic v;      // pair carries live data
    logic first;  // first pair of a pass: restart the sum
    logic last;   // last pair of a pass: the sum is complete
  } tap_tag_t;
endpackage

// File: rtl/decim_dual_read_ram.sv
module decim_dual_read_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  logic [AW-1:0] ra [2];
  assign ra[0] = raddr0;
  assign ra[1] = raddr1;

  // Two copies share the write port, and each copy serves one read port.
  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      q <= mem[ra[c]];
    end
  end

  assign rdata0 = g_copy[0].q;
  assign rdata1 = g_copy[1].q;
endmodule

// File: rtl/decim_mac_lane.sv
module decim_mac_lane
  import decim_pkg::*;
#(
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int ACCW  = 40,
  parameter int OW    = 18,
  parameter int SHIFT = 15,
  localparam int PW   = W + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  tap_tag_t             tag_in,
  input  logic signed [W-1:0]  x0,
  input  logic signed [W-1:0]  x1,
  input  logic signed [CW-1:0] h0,
  input  logic signed [CW-1:0] h1,
  output logic signed [OW-1:0] y,
  output logic                 y_v
);
  localparam logic signed [ACCW-1:0] HI = ACCW'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] LO = -HI - ACCW'(1);

  tap_tag_t                b_tag;
  logic signed [PW-1:0]    p0, p1;
  logic signed [ACCW-1:0]  acc, pair_sum, scaled;

  assign pair_sum = ACCW'(p0) + ACCW'(p1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      b_tag <= '0;
      p0    <= '0;
      p1    <= '0;
      acc   <= '0;
      y_v   <= 1'b0;
    end else begin
      b_tag <= tag_in;
      p0    <= PW'(x0) * PW'(h0);
      p1    <= PW'(x1) * PW'(h1);
      y_v   <= b_tag.v && b_tag.last;
      if (b_tag.v) acc <= b_tag.first ? pair_sum : acc + pair_sum;
    end
  end

  // Scale, then clamp to the output width (R8)
  assign scaled = acc >>> SHIFT;
  assign y = (scaled > HI) ? OW'(HI) :
             (scaled < LO) ? OW'(LO) : scaled[OW-1:0];

  // R2: tap pairs of one pass reach the accumulator in back-to-back cycles
  assert_pass_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
    (b_tag.v && !b_tag.first) |-> $past(b_tag.v));
endmodule

// File: rtl/decim_fir_engine.sv
module decim_fir_engine
  import decim_pkg::*;
#(
  parameter int W      = 16,
  parameter int CW     = 16,
  parameter int MAXLOG = 4,
  parameter int TPD    = 8,
  localparam int NMAX  = TPD << MAXLOG,
  localparam int CAW   = $clog2(NMAX),
  localparam int DEPTH = 2 * NMAX,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = W + 2,
  localparam int ACCW  = W + CW + CAW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     rate_sel,
  input  logic           in_valid,
  input  logic [W-1:0]   in_i,
  input  logic [W-1:0]   in_q,
  input  logic           cw_en,
  input  logic [CAW-1:0] cw_addr,
  input  logic [CW-1:0]  cw_data,
  output logic           out_valid,
  output logic [OW-1:0]  out_i,
  output logic [OW-1:0]  out_q
);
  logic [2:0]        cur_log, new_log;
  logic              chg, byp, take, trig, filled;
  logic [CAW:0]      fill_cnt, ntaps;
  logic [MAXLOG-1:0] ph, dec_m1;
  logic [MAXLOG:0]   dec_full;
  logic [AW-1:0]     wr_ptr, base, ra0, ra1;
  logic              busy;
  logic [CAW-2:0]    j, jl;
  tap_tag_t          rd_tag, a_tag;
  logic [2*W-1:0]    xs0, xs1;
  logic [CW-1:0]     hc0, hc1;
  logic signed [OW-1:0] lane_y [2];
  logic              lane_v [2];

  // R1: select values above the largest factor use the largest factor
  assign new_log  = (rate_sel > 3'(MAXLOG)) ? 3'(MAXLOG) : rate_sel;
  assign chg      = (new_log != cur_log);
  assign byp      = (cur_log == 3'd0);
  assign ntaps    = (CAW+1)'(TPD) << cur_log;
  assign jl       = ((CAW-1)'(TPD/2) << cur_log) - (CAW-1)'(1);
  assign dec_full = ((MAXLOG+1)'(1) << cur_log) - (MAXLOG+1)'(1);
  assign dec_m1   = dec_full[MAXLOG-1:0];
  assign filled   = (fill_cnt == ntaps);
  assign take     = in_valid && !chg && !byp;
  assign trig     = take && (filled ? (ph == dec_m1) : (fill_cnt == ntaps - 1'b1));

  // Tap walk: pair j reads taps 2j and 2j+1 back from the newest sample
  assign ra0 = base - {j, 1'b0};
  assign ra1 = ra0 - AW'(1);
  assign rd_tag = '{v: busy, first: (j == '0), last: (j == jl)};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_log   <= '0;
      fill_cnt  <= '0;
      ph        <= '0;
      wr_ptr    <= '0;
      base      <= '0;
      busy      <= 1'b0;
      j         <= '0;
      a_tag     <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      a_tag     <= chg ? '0 : rd_tag;
      out_valid <= 1'b0;
      if (chg) begin
        cur_log  <= new_log;
        fill_cnt <= '0;
        ph       <= '0;
        busy     <= 1'b0;
        j        <= '0;
      end else begin
        if (take) begin
          wr_ptr <= wr_ptr + AW'(1);
          if (!filled) fill_cnt <= fill_cnt + 1'b1;
          if (trig) ph <= '0;
          else if (filled) ph <= ph + 1'b1;
        end
        if (trig) begin
          busy <= 1'b1;
          j    <= '0;
          base <= wr_ptr;
        end else if (busy) begin
          j <= j + 1'b1;
          if (j == jl) busy <= 1'b0;
        end
        if (byp && in_valid) begin
          out_valid <= 1'b1;
          out_i     <= {{(OW-W){in_i[W-1]}}, in_i};
          out_q     <= {{(OW-W){in_q[W-1]}}, in_q};
        end else if (lane_v[0] && lane_v[1]) begin
          out_valid <= 1'b1;
          out_i     <= lane_y[0];
          out_q     <= lane_y[1];
        end
      end
    end
  end

  decim_dual_read_ram #(.DW(2*W), .DEPTH(DEPTH)) u_samples (
    .clk(clk), .we(take), .waddr(wr_ptr), .wdata({in_i, in_q}),
    .raddr0(ra0), .raddr1(ra1), .rdata0(xs0), .rdata1(xs1)
  );

  decim_dual_read_ram #(.DW(CW), .DEPTH(NMAX)) u_coefs (
    .clk(clk), .we(cw_en), .waddr(cw_addr), .wdata(cw_data),
    .raddr0({j, 1'b0}), .raddr1({j, 1'b1}), .rdata0(hc0), .rdata1(hc1)
  );

  // Lane 0 takes the I rail, lane 1 the Q rail
  for (genvar g = 0; g < 2; g++) begin : g_lane
    decim_mac_lane #(.W(W), .CW(CW), .ACCW(ACCW), .OW(OW), .SHIFT(CW-1)) u_lane (
      .clk(clk), .rst(rst), .clr(chg), .tag_in(a_tag),
      .x0(xs0[(2-g)*W-1 -: W]), .x1(xs1[(2-g)*W-1 -: W]),
      .h0(hc0), .h1(hc1), .y(lane_y[g]), .y_v(lane_v[g])
    );
  end

  // R2: input strobes are at least four cycles apart
  assert_in_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !$past(in_valid) && !$past(in_valid, 2) && !$past(in_valid, 3));
  // R2: a new pass starts only when the previous one is idle or on its final pair
  assert_pass_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    trig |-> (!busy || j == jl));
  // R6: no filtered output before the history holds N samples
  assert_no_early_output_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !byp) |-> filled);
  // R4: bypass passes samples through after one clock
  assert_bypass_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (byp && $past(byp) && $past(in_valid) && !$past(chg)) |->
      (out_valid && out_i == {{(OW-W){$past(in_i[W-1])}}, $past(in_i)}));
  // R7: a rate change silences the output on the following clock
  assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    chg |=> !out_valid);
endmodule

// File: tb/tb_decim_fir_engine.sv
module tb_decim_fir_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rate_sel = 3'd0;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic        cw_en = 1'b0;
  logic [6:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic        out_valid;
  logic [17:0] out_i, out_q;

  int checks = 0, fails = 0;
  int h [128];
  int hist_i [$], hist_q [$];
  longint exp_i [$], exp_q [$];
  string  exp_r [$];
  int scount = 0, cur_lg = 0, seg_outs = 0;
  string cur_label = "R3";

  always #10 clk = ~clk;

  decim_fir_engine dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .cw_en(cw_en), .cw_addr(cw_addr),
    .cw_data(cw_data), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint sat18(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic int map_log(input int sel);
    return (sel > 4) ? 4 : sel;
  endfunction

  // Reference model of one accepted sample
  task automatic model_take(input int xi, input int xq);
    int n, d;
    longint ai, aq;
    if (cur_lg == 0) begin
      exp_i.push_back(xi); exp_q.push_back(xq); exp_r.push_back("R4");
      return;
    end
    hist_i.push_back(xi); hist_q.push_back(xq);
    scount++;
    n = 8 << cur_lg; d = 1 << cur_lg;
    if (scount >= n && (scount - n) % d == 0) begin
      ai = 0; aq = 0;
      for (int k = 0; k < n; k++) begin
        ai += longint'(h[k]) * longint'(hist_i[hist_i.size()-1-k]);
        aq += longint'(h[k]) * longint'(hist_q[hist_q.size()-1-k]);
      end
      exp_i.push_back(sat18(ai >>> 15));
      exp_q.push_back(sat18(aq >>> 15));
      exp_r.push_back(cur_label);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      seg_outs++;
      if (exp_i.size() == 0) begin
        check(1'b0, "R6", "unexpected out_valid", 1, 0);
      end else begin
        string r;
        longint ei, eq;
        r = exp_r.pop_front(); ei = exp_i.pop_front(); eq = exp_q.pop_front();
        check(longint'($signed(out_i)) == ei, r, "out_i", longint'($signed(out_i)), ei);
        check(longint'($signed(out_q)) == eq, r, "out_q", longint'($signed(out_q)), eq);
      end
    end
  end

  task automatic load_coef(input int k, input int v);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = 7'(k); cw_data = 16'(v); h[k] = v;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic push(input int xi, input int xq, input int gap);
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
    model_take(xi, xq);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  // R7: change the rate; the model is cleared one clock later
  task automatic set_rate(input int sel);
    @(negedge clk);
    rate_sel = 3'(sel);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after rate change", out_valid, 0);
    exp_i.delete(); exp_q.delete(); exp_r.delete();
    hist_i.delete(); hist_q.delete();
    scount = 0; cur_lg = map_log(sel);
    repeat (2) @(negedge clk);
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom())));
  endfunction

  task automatic finish_seg(input int k, input string req);
    int n, d, want;
    repeat (300) @(negedge clk);
    check(exp_i.size() == 0, "R5", "outputs still owed", exp_i.size(), 0);
    n = 8 << cur_lg; d = 1 << cur_lg;
    if (cur_lg == 0) want = k;
    else if (k < n) want = 0;
    else want = (k - n) / d + 1;
    check(seg_outs == want, req, "output count", seg_outs, want);
  endtask

  task automatic rand_seg(input int sel, input int k, input bit fixed_gap, input string req);
    set_rate(sel);
    seg_outs = 0;
    for (int s = 0; s < k; s++)
      push(rnd16(), rnd16(), fixed_gap ? 4 : 4 + int'($urandom_range(0, 2)));
    finish_seg(k, req);
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(out_i == '0 && out_q == '0, "R10", "out data in reset", longint'(out_i), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_i == '0, "R10", "out after reset", out_valid, 0);

    for (int k = 0; k < 128; k++) load_coef(k, int'($urandom_range(0, 4094)) - 2047);

    cur_label = "R3";
    rand_seg(1, 40, 1'b0, "R5");   // factor 2, 16 taps
    rand_seg(0, 25, 1'b0, "R4");   // bypass
    rand_seg(2, 50, 1'b0, "R5");   // factor 4, 32 taps
    rand_seg(3, 90, 1'b1, "R2");   // factor 8 at the fastest input rate
    rand_seg(7, 165, 1'b0, "R1");  // select 7 acts as factor 16, 128 taps

    // R9: tap ordering with distinct coefficients and sparse impulses
    for (int k = 0; k < 16; k++) load_coef(k, 1000 * (k + 1));
    cur_label = "R9";
    set_rate(1);
    seg_outs = 0;
    for (int s = 0; s < 30; s++)
      push((s == 0 || s == 5 || s == 17) ? 32767 : 0, (s == 3) ? -32768 : 0, 4);
    finish_seg(30, "R9");

    // R7: partial fill at factor 4, then switch to factor 2 without draining
    cur_label = "R7";
    set_rate(2);
    for (int s = 0; s < 20; s++) push(32000, -32000, 4);
    set_rate(1);
    seg_outs = 0;
    for (int s = 0; s < 22; s++) push(rnd16(), rnd16(), 5);
    finish_seg(22, "R7");

    // R7: abort a pass in flight
    set_rate(2);
    for (int s = 0; s < 36; s++) push(rnd16(), rnd16(), 4);
    set_rate(3);
    seg_outs = 0;
    for (int s = 0; s < 70; s++) push(rnd16(), rnd16(), 4);
    finish_seg(70, "R7");

    // R8: saturation, positive on I and negative on Q
    for (int k = 0; k < 16; k++) load_coef(k, 32767);
    cur_label = "R8";
    set_rate(0);
    set_rate(1);
    seg_outs = 0;
    for (int s = 0; s < 20; s++) push(32767, -32768, 4);
    finish_seg(20, "R8");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule